// File: doc/BRIEF.md
# Page ECC Result Summarizer

After a page read, the decoder leaves one 64-bit status word per sector. This block walks those words, one per accepted beat, and reduces them to a page-level result. The result has five parts: the largest per-sector correction count, the sum of corrected bits, the number of sectors that could not be corrected, and two flags. One flag marks a page that is really erased. The other marks a sector whose decoding had not finished. The block also collects the two protected spare-area bytes that each status word carries, and lays them out as one flat byte vector for the page.

Software or a sequencer pulses `start_i` with the sector count, the scrambler setting and the ECC strength. It then streams the status words with `stat_valid_i`, and waits for the one-cycle `done_o`. A scrambled page that was never programmed decodes as uncorrectable, because the scrambler turns an all-ones page into noise. Such a sector is checked again using its zero-bit count. When that count is small, the page is reported as erased rather than failed.

Top module: `ecc_page_summarizer`

## Requirements
- R1: A `start_i` pulse latches the configuration and clears every result, the flags and the byte vector to zero on the next clock. If the clamped sector count is non-zero, `busy_o` goes high. A start while busy restarts the page.
- R2: The status word fields are: bit 31 is the sector-complete flag, bits 29:24 are the correction count (63 means uncorrectable), bits 21:16 are the zero-bit count, and bits 7:0 and 15:8 are the two user bytes. Bits 63:32 are ignored. For sector i, the user bytes appear at `oob_o[16i+7:16i]` and `oob_o[16i+15:16i+8]`.
- R3: A complete sector with a count below 63 adds its count to `corr_total_o`. `max_flips_o` holds the largest such count seen on the page.
- R4: An uncorrectable sector that is not treated as erased increments `fail_count_o` and stores its user bytes. Processing then continues with the next sector.
- R5: An uncorrectable sector is treated as erased when scrambling is on and its zero count is strictly below the strength. The walk then stops at once: `erased_o` is set, all of `oob_o` becomes 0xFF, later words are ignored, and the counters keep the values from the earlier sectors.
- R6: A word with bit 31 clear stops the walk and sets `not_ready_o`. That sector changes neither the counters nor the byte vector.
- R7: `done_o` is high for exactly the one clock after the last sector (or an early stop) is accepted, and `busy_o` is then low. A sector count of 0 gives `done_o` on the clock after start, with zero results. Counts above 16 are clamped to 16.
- R8: Status words presented while the block is not busy have no effect on any output.
- R9: While reset is asserted, and after it, all outputs are zero until the first start. Reset is asynchronous on assertion and synchronous on release.
- R10: The scrambler setting and the strength are taken only at start. Changing those inputs during a walk has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a page; clears results |
| sec_count_i | input | 5 | Sectors in the page (clamped to 16) |
| scramble_en_i | input | 1 | Page was written scrambled |
| strength_i | input | 6 | Configured ECC strength in bits |
| stat_valid_i | input | 1 | Status word present this cycle |
| stat_word_i | input | 64 | Per-sector status word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| max_flips_o | output | 6 | Largest correction count |
| corr_total_o | output | 10 | Sum of corrected bits |
| fail_count_o | output | 5 | Uncorrectable sector count |
| erased_o | output | 1 | Page judged erased |
| not_ready_o | output | 1 | A sector was not complete |
| oob_o | output | 256 | User bytes, two per sector |

## Verification
The bound checker watches, on every clock, the properties that relate outputs to one another or to their own history:
- `done_o` never coincides with `busy_o`.
- The maximum never reaches the uncorrectable code and never exceeds the running total.
- The total only grows during a walk.
- The two flags are exclusive, and an erased result always comes with an all-0xFF byte vector.
- A start leaves a cleared result one clock later.

Only the bench's page scenarios can show the sector-by-sector behaviour:
- the exact sums and failure counts,
- where in the byte vector each sector's bytes land,
- the strict zero-count threshold for the erased decision,
- that an early stop, idle words, an over-range count and configuration changes during a walk leave the results alone.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;
  localparam int STAT_W    = 64;
  localparam int FLIP_W    = 6;
  localparam int DONE_BIT  = 31;
  localparam int FLIP_LSB  = 24;
  localparam int ZERO_LSB  = 16;
  localparam int UBYTES_W  = 16;
  localparam logic [FLIP_W-1:0] FLIP_UNCORR = '1;

  typedef enum logic [1:0] {
    SEC_GOOD    = 2'd0,
    SEC_BAD     = 2'd1,
    SEC_BLANK   = 2'd2,
    SEC_PENDING = 2'd3
  } sec_kind_e;
endpackage

// File: rtl/ecc_sector_classify.sv
module ecc_sector_classify
  import ecc_agg_pkg::*;
(
  input  logic [STAT_W-1:0]   word_i,
  input  logic                scr_i,
  input  logic [FLIP_W-1:0]   strength_i,
  output sec_kind_e           kind_o,
  output logic [FLIP_W-1:0]   flips_o,
  output logic [UBYTES_W-1:0] ubytes_o
);
  logic              complete;
  logic [FLIP_W-1:0] zeros;

  assign complete = word_i[DONE_BIT];
  assign flips_o  = word_i[FLIP_LSB +: FLIP_W];
  assign zeros    = word_i[ZERO_LSB +: FLIP_W];
  assign ubytes_o = word_i[UBYTES_W-1:0];

  always_comb begin
    if (!complete) begin
      kind_o = SEC_PENDING;
    end else if (flips_o != FLIP_UNCORR) begin
      kind_o = SEC_GOOD;
    end else if (scr_i && (zeros < strength_i)) begin
      kind_o = SEC_BLANK;
    end else begin
      kind_o = SEC_BAD;
    end
  end
endmodule

// File: rtl/ecc_flip_accum.sv
module ecc_flip_accum
  import ecc_agg_pkg::*;
#(
  parameter int TOT_W  = 10,
  parameter int FAIL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  sec_kind_e         kind_i,
  input  logic [FLIP_W-1:0] flips_i,
  output logic [FLIP_W-1:0] max_o,
  output logic [TOT_W-1:0]  total_o,
  output logic [FAIL_W-1:0] fails_o
);
  logic [FLIP_W-1:0] max_q, max_n;
  logic [TOT_W-1:0]  tot_q, tot_n;
  logic [FAIL_W-1:0] fail_q, fail_n;
  logic              upd;

  assign upd = clr_i | en_i;

  always_comb begin
    max_n  = max_q;
    tot_n  = tot_q;
    fail_n = fail_q;
    if (clr_i) begin
      max_n  = '0;
      tot_n  = '0;
      fail_n = '0;
    end else if (en_i) begin
      if (kind_i == SEC_GOOD) begin
        tot_n = tot_q + TOT_W'(flips_i);
        if (flips_i > max_q) max_n = flips_i;
      end else if (kind_i == SEC_BAD) begin
        fail_n = fail_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q  <= '0;
      tot_q  <= '0;
      fail_q <= '0;
    end else if (upd) begin
      max_q  <= max_n;
      tot_q  <= tot_n;
      fail_q <= fail_n;
    end
  end

  assign max_o   = max_q;
  assign total_o = tot_q;
  assign fails_o = fail_q;
endmodule

// File: rtl/ecc_ubyte_store.sv
module ecc_ubyte_store
  import ecc_agg_pkg::*;
#(
  parameter int SECTORS = 16,
  parameter int IDX_W   = $clog2(SECTORS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        fill_i,
  input  logic                        wr_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [UBYTES_W-1:0]         bytes_i,
  output logic [SECTORS*UBYTES_W-1:0] vec_o
);
  for (genvar s = 0; s < SECTORS; s++) begin : g_slot
    logic [UBYTES_W-1:0] cur_q, nxt;
    logic                sel, en;

    assign sel = wr_i && (idx_i == IDX_W'(s));
    assign en  = clr_i | fill_i | sel;

    always_comb begin
      if (clr_i)       nxt = '0;
      else if (fill_i) nxt = '1;
      else             nxt = bytes_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cur_q <= '0;
      else if (en) cur_q <= nxt;
    end

    assign vec_o[s*UBYTES_W +: UBYTES_W] = cur_q;
  end
endmodule

// File: rtl/ecc_page_summarizer.sv
module ecc_page_summarizer
  import ecc_agg_pkg::*;
#(
  parameter int MAX_SECTORS = 16,
  parameter int SEL_W       = $clog2(MAX_SECTORS + 1),
  parameter int TOT_W       = FLIP_W + $clog2(MAX_SECTORS),
  parameter int FAIL_W      = $clog2(MAX_SECTORS + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic [SEL_W-1:0]                sec_count_i,
  input  logic                            scramble_en_i,
  input  logic [FLIP_W-1:0]               strength_i,
  input  logic                            stat_valid_i,
  input  logic [STAT_W-1:0]               stat_word_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic [FLIP_W-1:0]               max_flips_o,
  output logic [TOT_W-1:0]                corr_total_o,
  output logic [FAIL_W-1:0]               fail_count_o,
  output logic                            erased_o,
  output logic                            not_ready_o,
  output logic [MAX_SECTORS*UBYTES_W-1:0] oob_o
);
  localparam int IDX_W = $clog2(MAX_SECTORS);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_SECTORS);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} walk_st_e;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  walk_st_e           st_q, st_n;
  logic [SEL_W-1:0]   idx_q, idx_n, lim_q, lim_n, lim_in;
  logic               scr_q, scr_n;
  logic [FLIP_W-1:0]  str_q, str_n;
  logic               done_q, done_n, er_q, er_n, nr_q, nr_n;
  logic               accept, last, stop;
  sec_kind_e          kind;
  logic [FLIP_W-1:0]  flips;
  logic [UBYTES_W-1:0] ubytes;

  ecc_sector_classify u_cls (
    .word_i     (stat_word_i),
    .scr_i      (scr_q),
    .strength_i (str_q),
    .kind_o     (kind),
    .flips_o    (flips),
    .ubytes_o   (ubytes)
  );

  assign lim_in = (sec_count_i > SEL_MAX) ? SEL_MAX : sec_count_i;
  assign accept = (st_q == ST_RUN) && stat_valid_i && !start_i;
  assign last   = (idx_q == SEL_W'(lim_q - 1'b1));
  assign stop   = accept && (last || kind == SEC_PENDING || kind == SEC_BLANK);

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    lim_n  = lim_q;
    scr_n  = scr_q;
    str_n  = str_q;
    er_n   = er_q;
    nr_n   = nr_q;
    done_n = 1'b0;
    if (start_i) begin
      st_n   = (lim_in == '0) ? ST_IDLE : ST_RUN;
      idx_n  = '0;
      lim_n  = lim_in;
      scr_n  = scramble_en_i;
      str_n  = strength_i;
      er_n   = 1'b0;
      nr_n   = 1'b0;
      done_n = (lim_in == '0);
    end else if (accept) begin
      idx_n = idx_q + 1'b1;
      if (kind == SEC_BLANK)   er_n = 1'b1;
      if (kind == SEC_PENDING) nr_n = 1'b1;
      if (stop) begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lim_q  <= '0;
      scr_q  <= 1'b0;
      str_q  <= '0;
      er_q   <= 1'b0;
      nr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_n;
      if (start_i || accept) begin
        st_q  <= st_n;
        idx_q <= idx_n;
        lim_q <= lim_n;
        scr_q <= scr_n;
        str_q <= str_n;
        er_q  <= er_n;
        nr_q  <= nr_n;
      end
    end
  end

  ecc_flip_accum #(.TOT_W(TOT_W), .FAIL_W(FAIL_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (start_i),
    .en_i    (accept),
    .kind_i  (kind),
    .flips_i (flips),
    .max_o   (max_flips_o),
    .total_o (corr_total_o),
    .fails_o (fail_count_o)
  );

  ecc_ubyte_store #(.SECTORS(MAX_SECTORS)) u_ub (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (start_i),
    .fill_i  (accept && kind == SEC_BLANK),
    .wr_i    (accept && (kind == SEC_GOOD || kind == SEC_BAD)),
    .idx_i   (idx_q[IDX_W-1:0]),
    .bytes_i (ubytes),
    .vec_o   (oob_o)
  );

  assign busy_o      = (st_q == ST_RUN);
  assign done_o      = done_q;
  assign erased_o    = er_q;
  assign not_ready_o = nr_q;
endmodule

// File: rtl/ecc_page_summarizer_chk.sv
module ecc_page_summarizer_chk #(
  parameter int MAX_SECTORS = 16,
  parameter int TOT_W       = 10,
  parameter int FAIL_W      = 5,
  parameter int OOB_W       = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [5:0]       max_flips_o,
  input logic [TOT_W-1:0] corr_total_o,
  input logic [FAIL_W-1:0] fail_count_o,
  input logic             erased_o,
  input logic             not_ready_o,
  input logic [OOB_W-1:0] oob_o
);
  // R1: a start leaves a cleared result one clock later
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (corr_total_o == '0 && fail_count_o == '0 && max_flips_o == '0
                 && !erased_o && !not_ready_o && oob_o == '0));

  // R3: the maximum is never the uncorrectable code and never exceeds the sum
  a_r3_max_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (max_flips_o != 6'h3F) && (TOT_W'(max_flips_o) <= corr_total_o));

  // R3: the sum only grows during a walk
  a_r3_total_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> (corr_total_o >= $past(corr_total_o)));

  // R4: failed sectors never exceed the sector limit
  a_r4_fail_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fail_count_o <= FAIL_W'(MAX_SECTORS));

  // R5: an erased page has an all-0xFF byte vector
  a_r5_erased_fill: assert property (@(posedge clk) disable iff (!rst_n)
    erased_o |-> (&oob_o));

  // R6: not-ready and erased never together
  a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(erased_o && not_ready_o));

  // R7: done only when not busy
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind ecc_page_summarizer ecc_page_summarizer_chk #(
  .MAX_SECTORS (MAX_SECTORS),
  .TOT_W       (TOT_W),
  .FAIL_W      (FAIL_W),
  .OOB_W       (MAX_SECTORS * 16)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .max_flips_o  (max_flips_o),
  .corr_total_o (corr_total_o),
  .fail_count_o (fail_count_o),
  .erased_o     (erased_o),
  .not_ready_o  (not_ready_o),
  .oob_o        (oob_o)
);

// File: tb/ecc_page_summarizer_tb_top.sv
module ecc_page_summarizer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 16;

  logic         clk, rst_n, start_i, scramble_en_i, stat_valid_i;
  logic [4:0]   sec_count_i;
  logic [5:0]   strength_i;
  logic [63:0]  stat_word_i;
  logic         busy_o, done_o, erased_o, not_ready_o;
  logic [5:0]   max_flips_o;
  logic [9:0]   corr_total_o;
  logic [4:0]   fail_count_o;
  logic [255:0] oob_o;

  ecc_page_summarizer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sec_count_i(sec_count_i),
    .scramble_en_i(scramble_en_i), .strength_i(strength_i),
    .stat_valid_i(stat_valid_i), .stat_word_i(stat_word_i),
    .busy_o(busy_o), .done_o(done_o), .max_flips_o(max_flips_o),
    .corr_total_o(corr_total_o), .fail_count_o(fail_count_o),
    .erased_o(erased_o), .not_ready_o(not_ready_o), .oob_o(oob_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] wq [MAXS+1];
  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit 31 complete, 29:24 count, 21:16 zeros, 15:8 / 7:0 user bytes (R2)
  function automatic logic [63:0] mk(bit c, int e, int z, int b0, int b1, int salt);
    logic [31:0] hi;
    hi = 32'h5A3C_96E1 ^ salt[31:0];
    return {hi, c, 1'b0, e[5:0], 2'b00, z[5:0], b1[7:0], b0[7:0]};
  endfunction

  task automatic run_page(input int cnt, input bit scr, input int str, input string nm);
    int lim, feed, e_max, e_tot, e_fail;
    bit e_er, e_nr;
    logic [255:0] e_oob;
    lim = (cnt > MAXS) ? MAXS : cnt;
    feed = lim; e_max = 0; e_tot = 0; e_fail = 0; e_er = 0; e_nr = 0; e_oob = '0;
    for (int i = 0; i < lim; i++) begin
      logic [63:0] w;
      int e, z;
      w = wq[i]; e = int'(w[29:24]); z = int'(w[21:16]);
      if (!w[31]) begin e_nr = 1; feed = i + 1; break; end
      if (e == 63) begin
        if (scr && z < str) begin e_er = 1; e_oob = '1; feed = i + 1; break; end
        e_fail++;
      end else begin
        e_tot += e;
        if (e > e_max) e_max = e;
      end
      e_oob[16*i +: 16] = w[15:0];
    end
    @(negedge clk);
    start_i = 1; sec_count_i = cnt[4:0]; scramble_en_i = scr; strength_i = str[5:0];
    stat_valid_i = 0;
    @(negedge clk);
    start_i = 0;
    scramble_en_i = ~scr; strength_i = ~str[5:0]; // R10: changes after start must not matter
    for (int i = 0; i < feed; i++) begin
      stat_valid_i = 1; stat_word_i = wq[i];
      @(negedge clk);
    end
    stat_valid_i = 0;
    chk({nm, " R7 done pulse"}, 256'(done_o), 256'(1));
    chk({nm, " R3 max"}, 256'(max_flips_o), 256'(e_max));
    chk({nm, " R3 total"}, 256'(corr_total_o), 256'(e_tot));
    chk({nm, " R4 fails"}, 256'(fail_count_o), 256'(e_fail));
    chk({nm, " R5 erased"}, 256'(erased_o), 256'(e_er));
    chk({nm, " R6 not ready"}, 256'(not_ready_o), 256'(e_nr));
    chk({nm, " R2 user bytes"}, oob_o, e_oob);
    @(negedge clk);
    chk({nm, " R7 done single"}, 256'({done_o, busy_o}), 256'(0));
  endtask

  task automatic idle_word(input logic [63:0] w, input string nm);
    logic [9:0] t0; logic [4:0] f0; logic [255:0] o0; logic er0;
    t0 = corr_total_o; f0 = fail_count_o; o0 = oob_o; er0 = erased_o;
    stat_valid_i = 1; stat_word_i = w;
    @(negedge clk);
    stat_valid_i = 0;
    @(negedge clk);
    chk({nm, " total unchanged"}, 256'(corr_total_o), 256'(t0));
    chk({nm, " fails unchanged"}, 256'(fail_count_o), 256'(f0));
    chk({nm, " bytes/flag unchanged"}, {oob_o[254:0], er0}, {o0[254:0], erased_o});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; sec_count_i = '0; scramble_en_i = 0; strength_i = '0;
    stat_valid_i = 0; stat_word_i = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {oob_o[245:0], corr_total_o}, '0);
    chk("R9 reset flags", 256'({busy_o, done_o, erased_o, not_ready_o, max_flips_o, fail_count_o}), 256'(0));
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R9 after release", 256'({busy_o, done_o, corr_total_o}), 256'(0));

    // main sweep: every sector count, scrambler off and on
    for (int n = 1; n <= MAXS; n++) begin
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < n; i++) begin
          int e;
          e = ((i + n) % 4 == 2) ? 63 : (i * 5 + n * 3) % 63;
          wq[i] = mk(1, e, (i * 3 + n) % 64, i * 16 + n, 255 - i * 7, i * n);
        end
        run_page(n, s[0], 8, $sformatf("sweep n=%0d scr=%0d R1", n, s));
      end
    end

    // erased threshold boundary
    for (int k = 0; k < 5; k++) begin
      int st;
      st = (k == 0) ? 1 : (k == 1) ? 7 : (k == 2) ? 31 : (k == 3) ? 63 : 0;
      wq[0] = mk(1, 2, 0, 8'h11, 8'h22, 1);
      wq[1] = mk(1, 63, st, 8'h33, 8'h44, 2);
      wq[2] = mk(1, 5, 0, 8'h55, 8'h66, 3);
      run_page(3, 1, st, $sformatf("R4 zeros=strength=%0d", st));
      if (st > 0) begin
        wq[1] = mk(1, 63, st - 1, 8'h33, 8'h44, 2);
        run_page(3, 1, st, $sformatf("R5 zeros below strength=%0d", st));
        idle_word(mk(1, 9, 0, 1, 2, 9), "R5 R8 word after erased stop");
      end
    end

    // R10: scrambled uncorrectable with few zeros while config inputs toggle
    wq[0] = mk(1, 63, 3, 1, 2, 0);
    run_page(2, 1, 10, "R10 latched config");
    chk("R10 erased via latched config", 256'(erased_o), 256'(1));

    // not-ready sector in the middle and first
    for (int i = 0; i < 4; i++) wq[i] = mk(1, i + 1, 0, i, i + 100, i);
    wq[2] = mk(0, 4, 0, 8'hAB, 8'hCD, 7);
    run_page(4, 0, 8, "R6 middle pending");
    wq[0] = mk(0, 1, 0, 8'hAB, 8'hCD, 7);
    run_page(4, 0, 8, "R6 first pending");

    // zero sectors, and clamp from 20 to 16
    run_page(0, 0, 8, "R7 zero count");
    for (int i = 0; i <= MAXS; i++) wq[i] = mk(1, 62 - i, 0, i + 1, i + 2, i);
    run_page(20, 0, 8, "R7 clamp");
    idle_word(wq[MAXS], "R7 R8 extra word after clamp");
    idle_word(mk(1, 63, 0, 9, 9, 4), "R8 idle bad word");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule